// File: doc/BRIEF.md
# Pulse-Programmed One-Time Memory Emulator

This block is a synthesizable, clocked stand-in for a 4096 x 8 ultraviolet-erasable read-only memory, seen from its pins. A host drives an address, an active-low chip select, an output-enable level and a flag meaning that the high programming supply is applied. The block works out the operating mode from those controls. It serves reads and verifies from its array, keeps its data bus undriven in standby, inhibit and programming, and accepts program pulses. A program pulse can only clear bits.

A program pulse is a low period on the chip select while the supply flag is high. The block measures the pulse in clock cycles, with a clocks-per-millisecond parameter. Only a pulse that lasts 45 to 55 ms and keeps its address and data steady changes the array. In that case the addressed word becomes its old value ANDed with the presented data, and the change is made at the clock edge where the select is first seen high again. Pulses that are too short or too long set a sticky width error. A pulse whose address or data moves, or that loses the supply, sets a sticky protocol error. Synchronous reset stands in for ultraviolet erasure: it sets every bit to 1 and clears both error flags.

Top module: `otp_prom_emu`

## Requirements
- R1: After reset every word reads back as 8'hFF, and both error flags are 0.
- R2: With chip select low, output enable low and the supply flag low, the block drives its data bus (drive enable 1) with the word at the current address. This data is due one clock edge after the inputs are sampled.
- R3: With chip select high, the drive enable is 0 whatever the output enable and supply flag are doing. Whenever the drive enable is 0, the output data bus reads 8'h00.
- R4: With chip select low, the supply flag low and output enable high, the drive enable is 0.
- R5: A pulse is valid when the chip select falls while the supply flag is high and is then sampled low on N clock edges, with 45*CLK_PER_MS <= N <= 55*CLK_PER_MS. A valid pulse writes old AND input data into the word at the address captured when the pulse began. Both bounds themselves are valid.
- R6: Programming never turns a 0 bit into a 1. A 1 in the input data leaves the stored bit unchanged.
- R7: A pulse with N below 45*CLK_PER_MS leaves the array unchanged and sets the width error flag. The flag stays set until reset.
- R8: A pulse still low on edge 55*CLK_PER_MS+1 sets the width error flag on that edge, while the select is still low. The array is left unchanged.
- R9: A change of address or input data during a pulse sets the protocol error flag, and the pulse writes nothing. The flag stays set until reset.
- R10: Dropping the supply flag during a pulse aborts it, writes nothing and sets the protocol error flag.
- R11: While the supply flag is high, the drive enable is 0.
- R12: With the supply flag high and chip select held high (inhibit), changes on address and input data leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; erases the array to all ones |
| addr | input | 12 | Word address |
| ce_n | input | 1 | Active-low chip select; carries the program pulse |
| oe_n | input | 1 | Active-low output enable level of the shared control pin |
| vpp_hi | input | 1 | High when the shared pin carries the programming supply |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Data to program |
| width_err | output | 1 | Sticky pulse width error |
| proto_err | output | 1 | Sticky pulse protocol error |

## Verification
Read data and drive enable come from a register. They are due one edge after the control and address inputs are sampled, so the bench changes inputs on a falling edge and compares on the next falling edge. A program write takes effect on the edge that first samples the select high. The bench makes that edge pass before it starts the next read, and the read result is then due one edge later. The width error for a pulse that is held too long appears on exactly the 55*CLK_PER_MS+1 low edge: the bench checks that the flag is still 0 after 55*CLK_PER_MS edges and is 1 after one more.

// File: rtl/otp_emu_pkg.sv
package otp_emu_pkg;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_INHIBIT,
      M_READ,
      M_OUTOFF,
      M_PROGRAM
   } otp_mode_e;

   typedef enum logic {
      PS_IDLE,
      PS_PULSE
   } pulse_st_e;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_emu_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      vpp_hi,
   output otp_mode_e mode
);

   always_comb begin
      if (ce_n) begin
         mode = vpp_hi ? M_INHIBIT : M_STANDBY;
      end else if (vpp_hi) begin
         mode = M_PROGRAM;
      end else begin
         mode = oe_n ? M_OUTOFF : M_READ;
      end
   end

endmodule

// File: rtl/otp_pulse_mon.sv
module otp_pulse_mon
   import otp_emu_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 8,
   parameter int MIN_CYC = 180,
   parameter int MAX_CYC = 220
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              vpp_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              width_err,
   output logic              proto_err
);

   localparam int CNT_W = $clog2(MAX_CYC + 2);
   localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_CYC);
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CYC);
   localparam logic [CNT_W-1:0] SAT_C = CNT_W'(MAX_CYC + 1);

   pulse_st_e         st;
   logic              ce_n_q;
   logic [CNT_W-1:0]  cnt;
   logic              dirty;
   logic              in_window;

   assign in_window = (cnt >= MIN_C) && (cnt <= MAX_C);
   assign wr_en     = (st == PS_PULSE) && vpp_hi && ce_n && in_window && !dirty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= PS_IDLE;
         ce_n_q    <= 1'b1;
         cnt       <= '0;
         dirty     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '1;
         width_err <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         ce_n_q <= ce_n;
         unique case (st)
            PS_IDLE: begin
               if (vpp_hi && !ce_n && ce_n_q) begin
                  st      <= PS_PULSE;
                  cnt     <= CNT_W'(1);
                  dirty   <= 1'b0;
                  wr_addr <= addr;
                  wr_data <= din;
               end
            end
            PS_PULSE: begin
               if (!vpp_hi) begin
                  st        <= PS_IDLE;
                  proto_err <= 1'b1;
               end else if (!ce_n) begin
                  if (cnt != SAT_C) cnt <= cnt + CNT_W'(1);
                  if (cnt == MAX_C) width_err <= 1'b1;
                  if ((addr != wr_addr) || (din != wr_data)) begin
                     dirty     <= 1'b1;
                     proto_err <= 1'b1;
                  end
               end else begin
                  st <= PS_IDLE;
                  if (cnt < MIN_C) width_err <= 1'b1;
               end
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) cells[w] <= '1;
      end else if (we) begin
         cells[waddr] <= cells[waddr] & wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/otp_prom_emu.sv
module otp_prom_emu
   import otp_emu_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int CLK_PER_MS = 4,
   parameter int MIN_MS     = 45,
   parameter int MAX_MS     = 55,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in,
   output logic              width_err,
   output logic              proto_err
);

   localparam int MIN_CYC = MIN_MS * CLK_PER_MS;
   localparam int MAX_CYC = MAX_MS * CLK_PER_MS;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("otp_prom_emu: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("otp_prom_emu: DATA_W must be positive");
   end
   if (CLK_PER_MS < 1 || MIN_MS < 1 || MAX_MS < MIN_MS) begin : g_bad_pulse
      $error("otp_prom_emu: pulse window parameters inconsistent");
   end

   otp_mode_e         mode;
   logic              drive_rq;
   logic              prog_we;
   logic [ADDR_W-1:0] prog_addr;
   logic [DATA_W-1:0] prog_data;
   logic [DATA_W-1:0] rd_word;

   otp_mode_decode u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_hi (vpp_hi),
      .mode   (mode)
   );

   assign drive_rq = (mode == M_READ);

   otp_pulse_mon #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .MIN_CYC (MIN_CYC),
      .MAX_CYC (MAX_CYC)
   ) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .vpp_hi    (vpp_hi),
      .addr      (addr),
      .din       (dq_in),
      .wr_en     (prog_we),
      .wr_addr   (prog_addr),
      .wr_data   (prog_data),
      .width_err (width_err),
      .proto_err (proto_err)
   );

   otp_cell_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prog_we),
      .waddr (prog_addr),
      .wdata (prog_data),
      .raddr (addr),
      .rdata (rd_word)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
         end else begin
            dq_oe  <= drive_rq;
            dq_out <= drive_rq ? rd_word : '0;
         end
      end
   end else begin : g_out_comb
      assign dq_oe  = drive_rq;
      assign dq_out = drive_rq ? rd_word : '0;
   end

endmodule

// File: rtl/otp_prom_emu_chk.sv
module otp_prom_emu_chk #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ce_n,
   input logic              oe_n,
   input logic              vpp_hi,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe,
   input logic              width_err,
   input logic              proto_err,
   input logic              prog_we
);

   // R3: an undriven bus carries zeros
   a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));

   // R7 / R8: width flag is sticky
   a_r7_width_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(width_err)) |-> width_err);

   // R9 / R10: protocol flag is sticky
   a_r9_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(proto_err)) |-> proto_err);

   // R5: a write only ends a low select with the supply present
   a_r5_write_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_we && $past(rst_n)) |-> ($past(!ce_n) && $past(vpp_hi)));

   // R10: no write without the supply
   a_r10_write_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we |-> vpp_hi);

   if (OUT_REG) begin : g_reg_checks
      // R3
      a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ce_n) |-> !dq_oe);
      // R11
      a_r11_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         $past(vpp_hi) |-> !dq_oe);
      // R4
      a_r4_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
         $past(oe_n && !vpp_hi) |-> !dq_oe);
      // R2
      a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && !ce_n && !oe_n && !vpp_hi) |-> dq_oe);
   end else begin : g_comb_checks
      a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         ce_n |-> !dq_oe);
      a_r11_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         vpp_hi |-> !dq_oe);
      a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
         (!ce_n && !oe_n && !vpp_hi) |-> dq_oe);
   end

   logic unused_addr;
   assign unused_addr = ^addr;

endmodule

bind otp_prom_emu otp_prom_emu_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .vpp_hi    (vpp_hi),
   .dq_out    (dq_out),
   .dq_oe     (dq_oe),
   .width_err (width_err),
   .proto_err (proto_err),
   .prog_we   (prog_we)
);

// File: tb/tb_otp_prom_emu.sv
`timescale 1ns/1ps
module tb_otp_prom_emu;

   localparam int CPM     = 4;
   localparam int MIN_CYC = 45 * CPM;
   localparam int MAX_CYC = 55 * CPM;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] addr;
   logic        ce_n, oe_n, vpp_hi;
   logic [7:0]  dq_out, dq_in;
   logic        dq_oe, width_err, proto_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   otp_prom_emu #(.CLK_PER_MS(CPM)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .vpp_hi(vpp_hi), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
      .width_err(width_err), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle(); addr = '0; dq_in = '1; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_word(input logic [11:0] a, output logic [7:0] d,
                            output logic oe);
      ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; addr = a;
      @(negedge clk);
      d = dq_out; oe = dq_oe;
      idle();
      @(negedge clk);
   endtask

   task automatic expect_word(input logic [11:0] a, input logic [7:0] e,
                              input string req);
      logic [7:0] d;
      logic oe;
      read_word(a, d, oe);
      chk(oe === 1'b1, req, "drive enable on read", int'(oe), 1);
      chk(d === e, req, "read data", int'(d), int'(e));
   endtask

   task automatic pulse(input logic [11:0] a, input logic [7:0] d, input int n);
      addr = a; dq_in = d; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (n) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      vpp_hi = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk(width_err === 1'b0, "R1", "width flag after reset", int'(width_err), 0);
      chk(proto_err === 1'b0, "R1", "proto flag after reset", int'(proto_err), 0);
      expect_word(12'h000, 8'hFF, "R1");
      expect_word(12'hFFF, 8'hFF, "R1");
      expect_word(12'h5A3, 8'hFF, "R1");
   endtask

   task automatic t_output_modes();
      do_reset();
      pulse(12'h010, 8'h3C, MIN_CYC);
      // R3 standby with oe low
      ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b0; addr = 12'h010;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R3", "standby drive", int'(dq_oe), 0);
      chk(dq_out === 8'h00, "R3", "standby bus", int'(dq_out), 0);
      // R4 output enable high
      ce_n = 1'b0; oe_n = 1'b1;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R4", "oe high drive", int'(dq_oe), 0);
      // R2 read one edge later
      oe_n = 1'b0;
      @(negedge clk);
      chk(dq_oe === 1'b1, "R2", "read drive", int'(dq_oe), 1);
      chk(dq_out === 8'h3C, "R2", "read data", int'(dq_out), 8'h3C);
      addr = 12'h011;
      @(negedge clk);
      chk(dq_out === 8'hFF, "R2", "read follows address", int'(dq_out), 8'hFF);
      idle();
      @(negedge clk);
   endtask

   task automatic t_program_bounds();
      do_reset();
      pulse(12'h123, 8'hA5, MIN_CYC);
      expect_word(12'h123, 8'hA5, "R5");
      pulse(12'h124, 8'h0F, MAX_CYC);
      expect_word(12'h124, 8'h0F, "R5");
      chk(width_err === 1'b0, "R5", "no width flag on bounds", int'(width_err), 0);
      chk(proto_err === 1'b0, "R5", "no proto flag", int'(proto_err), 0);
   endtask

   task automatic t_clear_only();
      do_reset();
      pulse(12'h200, 8'hF0, 200);
      pulse(12'h200, 8'h3F, 200);
      expect_word(12'h200, 8'h30, "R6");
      pulse(12'h200, 8'hFF, 200);
      expect_word(12'h200, 8'h30, "R6");
   endtask

   task automatic t_prog_bus_off();
      do_reset();
      addr = 12'h300; dq_in = 8'h00; vpp_hi = 1'b1; oe_n = 1'b0; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(dq_oe === 1'b0, "R11", "drive during pulse", int'(dq_oe), 0);
      repeat (MIN_CYC - 5) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R11", "drive during inhibit", int'(dq_oe), 0);
      idle();
      @(negedge clk);
      expect_word(12'h300, 8'h00, "R11");
   endtask

   task automatic t_short();
      do_reset();
      pulse(12'h400, 8'h00, MIN_CYC - 1);
      chk(width_err === 1'b1, "R7", "short pulse flag", int'(width_err), 1);
      expect_word(12'h400, 8'hFF, "R7");
      pulse(12'h401, 8'h55, 200);
      chk(width_err === 1'b1, "R7", "flag stays set", int'(width_err), 1);
   endtask

   task automatic t_long();
      do_reset();
      addr = 12'h500; dq_in = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (MAX_CYC) @(negedge clk);
      chk(width_err === 1'b0, "R8", "flag before limit", int'(width_err), 0);
      @(negedge clk);
      chk(width_err === 1'b1, "R8", "flag past limit", int'(width_err), 1);
      repeat (10) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      idle();
      @(negedge clk);
      expect_word(12'h500, 8'hFF, "R8");
   endtask

   task automatic t_moving_inputs();
      do_reset();
      addr = 12'h600; dq_in = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (50) @(negedge clk);
      addr = 12'h601;
      repeat (150) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk(proto_err === 1'b1, "R9", "address move flag", int'(proto_err), 1);
      expect_word(12'h600, 8'hFF, "R9");
      expect_word(12'h601, 8'hFF, "R9");
      do_reset();
      addr = 12'h610; dq_in = 8'h0F; vpp_hi = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (100) @(negedge clk);
      dq_in = 8'h00;
      repeat (100) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk(proto_err === 1'b1, "R9", "data move flag", int'(proto_err), 1);
      expect_word(12'h610, 8'hFF, "R9");
   endtask

   task automatic t_supply_drop();
      do_reset();
      addr = 12'h700; dq_in = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (190) @(negedge clk);
      vpp_hi = 1'b0;
      repeat (3) @(negedge clk);
      vpp_hi = 1'b1;
      repeat (10) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk(proto_err === 1'b1, "R10", "supply drop flag", int'(proto_err), 1);
      expect_word(12'h700, 8'hFF, "R10");
   endtask

   task automatic t_inhibit();
      do_reset();
      vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
      for (int i = 0; i < 20; i++) begin
         addr = 12'h800 + 12'(i % 4); dq_in = 8'(i * 7);
         @(negedge clk);
         chk(dq_oe === 1'b0, "R12", "inhibit drive", int'(dq_oe), 0);
      end
      idle();
      @(negedge clk);
      for (int j = 0; j < 4; j++) expect_word(12'h800 + 12'(j), 8'hFF, "R12");
   endtask

   initial begin
      rst_n = 1'b0;
      idle(); addr = '0; dq_in = '1;
      t_reset_state();
      t_output_modes();
      t_program_bounds();
      t_clear_only();
      t_prog_bus_off();
      t_short();
      t_long();
      t_moving_inputs();
      t_supply_drop();
      t_inhibit();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule